// File: doc/BRIEF.md
# Light Sensor Integration Controller

This block is the digital core of an integrating light-to-digital converter. A byte-wide command register sets how long each integration period lasts and where its boundaries come from. During a period the block counts photodiode pulses, which stand in for the analog front end, and it counts oscillator-rate enable ticks as its timebase. When a period ends, the 16-bit result goes into two byte-wide data registers. A one-cycle done strobe marks the load, and the next period starts at once.

There are two timing modes. In the internal mode the period is a fixed power-of-two number of oscillator ticks. In the external mode, pulses on a sync input mark the period's edges. In external mode one command code makes the data registers hold the tick count of the last period, so that software can scale the light count against it. Every other external code makes them hold the photodiode count. A two-bit range field is stored and driven out unchanged for the analog side.

Top module: `lightIntegCtrl`

## Requirements
- R1: After reset the command register, both data registers, the range output and the done strobe are all zero.
- R2: With command bit 4 at 0 (internal timing), command bits 3:2 set the period length in oscillator ticks: 11 gives 16, 10 gives 256, 01 gives 4096 and 00 gives 65536. A period covers the cycles after the one that started it, up to and including the cycle of its last tick.
- R3: In internal timing, the stored value is the number of clock cycles with the photodiode input high during the period, saturated at 2^n − 1, where 2^n is the period length.
- R4: With command bit 4 at 1 (external timing), the first sync pulse after a command write opens a period and loads nothing. Each later sync pulse closes the open period, loads the result and opens the next period. Events in the closing cycle count toward the period being closed.
- R5: In external timing, a command with bit 7 at 1 and bits 3:2 at 01 (pattern 1xx101xx) loads the number of oscillator ticks in the period. Any other external command, including 1xx100xx, loads the photodiode count.
- R6: In external timing, both counts saturate at 65535.
- R7: A write to the command register (address 0) discards the period in progress and starts a new period under the new settings. No load happens in the cycle after the write.
- R8: The done strobe is high for exactly the one cycle in which freshly loaded data first appears, and the data registers change at no other time. A read at address 1 returns the low result byte, at address 2 the high byte, and at address 0 the command.
- R9: Command bits 1:0 appear on the range output from the cycle after the write and do not affect any count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write enable (only address 0 is writable) |
| regAddr | input | 2 | Register address for read and write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| oscTick | input | 1 | Oscillator-rate enable, one tick per high cycle |
| syncPulse | input | 1 | External period boundary pulse |
| photoPulse | input | 1 | Photodiode pulse, one count per high cycle |
| dataLo | output | 8 | Result register, low byte |
| dataHi | output | 8 | Result register, high byte |
| rangeCode | output | 2 | Stored range field |
| convDone | output | 1 | One-cycle load strobe |

## Verification
Internal periods of 16, 256 and 4096 ticks are run with the photodiode input never high, always high, high every other cycle and high every fourth cycle. The always-high pattern shows the saturation limit of each length. The sparse patterns show an exact count and the exact cycle of the done strobe. External periods use the tick-count command, the photodiode-count command and a command that has bit 7 clear. Photodiode activity differs from the tick rate in each case, so a wrong selection shows up as a different value. A run longer than 65535 cycles exposes the external saturation limit. A rewrite part way through a period checks that the old period is dropped and no stale strobe appears.

// File: rtl/licPkg.sv
package licPkg;
  localparam int DATA_W_DEF   = 8;
  localparam int RES_STEP_DEF = 4;
  // command field positions (decoded by neighbouring logic)
  localparam int SEL_BIT   = 7;
  localparam int MODE_BIT  = 4;
  localparam int RES_HI    = 3;
  localparam int RES_LO    = 2;
  localparam logic [1:0] TIMER_RES_CODE = 2'b01;

  typedef struct packed {
    logic clearCnt;
    logic loadRes;
    logic selTimer;
  } ctlStrobe_t;
endpackage

// File: rtl/licControl.sv
module licControl
  import licPkg::*;
#(
  parameter int CMD_W = DATA_W_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWr,
  input  logic [CMD_W-1:0] cmdData,
  input  logic             syncPulse,
  input  logic             lastTick,
  output logic [CMD_W-1:0] cmdQ,
  output logic             extMode,
  output ctlStrobe_t       strobe
);
  logic winOpen;

  assign extMode = cmdQ[MODE_BIT];

  always_comb begin
    strobe = '0;
    strobe.selTimer = extMode && cmdQ[SEL_BIT] && (cmdQ[RES_HI:RES_LO] == TIMER_RES_CODE);
    if (cmdWr) begin
      strobe.clearCnt = 1'b1;
    end else if (extMode) begin
      if (syncPulse) begin
        strobe.clearCnt = 1'b1;
        strobe.loadRes  = winOpen;
      end
    end else if (lastTick) begin
      strobe.clearCnt = 1'b1;
      strobe.loadRes  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ    <= '0;
      winOpen <= 1'b0;
    end else if (cmdWr) begin
      cmdQ    <= cmdData;
      winOpen <= 1'b0;
    end else if (extMode && syncPulse) begin
      winOpen <= 1'b1;
    end
  end
endmodule

// File: rtl/licDatapath.sv
module licDatapath
  import licPkg::*;
#(
  parameter int CNT_W    = 2 * DATA_W_DEF,
  parameter int RES_STEP = RES_STEP_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscTick,
  input  logic             photoPulse,
  input  logic [1:0]       resCode,
  input  logic             extMode,
  input  ctlStrobe_t       strobe,
  output logic             lastTick,
  output logic [CNT_W-1:0] result,
  output logic             done
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cycleCnt, cycNext;
  logic [CNT_W-1:0] pulseCnt, pulseNext;
  logic [CNT_W-1:0] lenMax, satMax;

  always_comb begin
    lenMax = ALL_ONES >> (RES_STEP * resCode);
    satMax = extMode ? ALL_ONES : lenMax;
    cycNext = cycleCnt;
    if (oscTick && (cycleCnt != ALL_ONES)) cycNext = cycleCnt + CNT_W'(1);
    pulseNext = pulseCnt;
    if (photoPulse && (pulseCnt < satMax)) pulseNext = pulseCnt + CNT_W'(1);
  end

  assign lastTick = oscTick && (cycleCnt == lenMax);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleCnt <= '0;
      pulseCnt <= '0;
      result   <= '0;
      done     <= 1'b0;
    end else begin
      if (strobe.clearCnt) begin
        cycleCnt <= '0;
        pulseCnt <= '0;
      end else begin
        cycleCnt <= cycNext;
        pulseCnt <= pulseNext;
      end
      if (strobe.loadRes) result <= strobe.selTimer ? cycNext : pulseNext;
      done <= strobe.loadRes;
    end
  end
endmodule

// File: rtl/lightIntegCtrl.sv
module lightIntegCtrl
  import licPkg::*;
#(
  parameter int DATA_W   = DATA_W_DEF,
  parameter int RES_STEP = RES_STEP_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              oscTick,
  input  logic              syncPulse,
  input  logic              photoPulse,
  output logic [DATA_W-1:0] dataLo,
  output logic [DATA_W-1:0] dataHi,
  output logic [1:0]        rangeCode,
  output logic              convDone
);
  localparam int CNT_W = 2 * DATA_W;

  logic [DATA_W-1:0] cmdQ;
  logic              extMode, lastTick, cmdWr;
  logic [CNT_W-1:0]  result;
  ctlStrobe_t        strobe;

  assign cmdWr = regWrEn && (regAddr == 2'd0);

  licControl #(.CMD_W(DATA_W)) u_ctl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdData(regWrData),
    .syncPulse(syncPulse), .lastTick(lastTick),
    .cmdQ(cmdQ), .extMode(extMode), .strobe(strobe)
  );

  licDatapath #(.CNT_W(CNT_W), .RES_STEP(RES_STEP)) u_dp (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .photoPulse(photoPulse),
    .resCode(cmdQ[RES_HI:RES_LO]), .extMode(extMode), .strobe(strobe),
    .lastTick(lastTick), .result(result), .done(convDone)
  );

  assign dataLo    = result[DATA_W-1:0];
  assign dataHi    = result[CNT_W-1:DATA_W];
  assign rangeCode = cmdQ[1:0];

  always_comb begin
    case (regAddr)
      2'd0:    regRdData = cmdQ;
      2'd1:    regRdData = dataLo;
      2'd2:    regRdData = dataHi;
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/licChecker.sv
module licChecker (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [1:0] regAddr,
  input logic [7:0] regWrData,
  input logic       syncPulse,
  input logic [7:0] dataLo,
  input logic [7:0] dataHi,
  input logic [1:0] rangeCode,
  input logic       convDone,
  input logic [7:0] cmdQ
);
  logic cmdWrite;
  assign cmdWrite = regWrEn && (regAddr == 2'd0);

  assert_sat_internal_R3: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && !cmdQ[4]) |-> ({dataHi, dataLo} <= (16'hFFFF >> (4 * cmdQ[3:2]))));

  assert_ext_load_on_sync_R4: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && cmdQ[4]) |-> $past(syncPulse));

  assert_no_load_after_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrite |=> !convDone);

  assert_data_moves_with_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({dataHi, dataLo}) |-> convDone);

  assert_range_follows_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrite |=> (rangeCode == $past(regWrData[1:0])));
endmodule

bind lightIntegCtrl licChecker u_licChecker (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .syncPulse(syncPulse), .dataLo(dataLo),
  .dataHi(dataHi), .rangeCode(rangeCode), .convDone(convDone), .cmdQ(cmdQ)
);

// File: tb/lightIntegCtrl_bench.sv
module lightIntegCtrl_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic       regWrEn;
  logic [1:0] regAddr;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       oscTick, syncPulse, photoPulse;
  logic [7:0] dataLo, dataHi;
  logic [1:0] rangeCode;
  logic       convDone;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  lightIntegCtrl u_lightIntegCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .oscTick(oscTick),
    .syncPulse(syncPulse), .photoPulse(photoPulse), .dataLo(dataLo),
    .dataHi(dataHi), .rangeCode(rangeCode), .convDone(convDone)
  );

  // {command, photo pattern}; pattern 0 none, 1 every cycle, 2 odd cycles, 3 every fourth
  localparam logic [9:0] VECS [8] = '{
    {8'h0C, 2'd1}, {8'h0D, 2'd2}, {8'h0E, 2'd3}, {8'h0F, 2'd0},
    {8'h08, 2'd1}, {8'h09, 2'd2}, {8'h04, 2'd3}, {8'h07, 2'd1}
  };

  function automatic logic patBit(int pat, int i);
    case (pat)
      1: return 1'b1;
      2: return (i % 2) == 1;
      3: return (i % 4) == 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(logic wr, logic [1:0] a, logic [7:0] d, logic tk, logic sy, logic ph);
    regWrEn = wr; regAddr = a; regWrData = d;
    oscTick = tk; syncPulse = sy; photoPulse = ph;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finishRun();
      end
    end
  end

  initial begin
    rstN = 1'b0;
    regWrEn = 0; regAddr = 0; regWrData = 0;
    oscTick = 0; syncPulse = 0; photoPulse = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    step(0, 2'd0, 8'h00, 0, 0, 0);
    // R1 reset state
    chk("R1 data", {dataHi, dataLo}, 0);
    chk("R1 done", convDone, 0);
    chk("R1 range", rangeCode, 0);
    chk("R1 cmd read", regRdData, 0);

    // internal-mode vector table (R2, R3, R8, R9)
    for (int v = 0; v < 8; v++) begin
      logic [7:0] cmd;
      int pat, len, cnt, exp;
      bit early;
      cmd = VECS[v][9:2];
      pat = int'(VECS[v][1:0]);
      len = 1 << (16 - 4 * int'(cmd[3:2]));
      cnt = 0;
      early = 0;
      step(1, 2'd0, cmd, 1, 0, 0);
      chk("R9 range", rangeCode, int'(cmd[1:0]));
      chk("R8 cmd read", regRdData, int'(cmd));
      for (int i = 1; i <= len; i++) begin
        logic ph;
        ph = patBit(pat, i);
        if (ph) cnt++;
        step(0, 2'd1, 8'h00, 1, 0, ph);
        if (i < len && convDone) early = 1;
      end
      exp = (cnt > len - 1) ? len - 1 : cnt;
      chk("R2 no early done", early, 0);
      chk("R2 done at period end", convDone, 1);
      chk("R3 count", {dataHi, dataLo}, exp);
      chk("R8 low byte read", regRdData, exp & 8'hFF);
      step(0, 2'd2, 8'h00, 1, 0, 0);
      chk("R8 high byte read", regRdData, exp >> 8);
      chk("R8 single-cycle done", convDone, 0);
    end

    // R7 abort: rewrite mid-period
    begin
      bit early;
      early = 0;
      step(1, 2'd0, 8'h0C, 1, 0, 0);
      repeat (10) step(0, 2'd1, 8'h00, 1, 0, 1);
      step(1, 2'd0, 8'h0C, 1, 0, 1);
      for (int i = 1; i <= 16; i++) begin
        step(0, 2'd1, 8'h00, 1, 0, patBit(2, i));
        if (i < 16 && convDone) early = 1;
      end
      chk("R7 old period dropped", early, 0);
      chk("R7 done after restart", convDone, 1);
      chk("R7 count after restart", {dataHi, dataLo}, 8);
    end

    // R4/R5 external, tick-count command 1xx101xx
    step(1, 2'd0, 8'h94, 1, 0, 0);
    step(0, 2'd1, 8'h00, 1, 0, 1);
    step(0, 2'd1, 8'h00, 1, 1, 1);
    chk("R4 opening sync loads nothing", convDone, 0);
    repeat (9) step(0, 2'd1, 8'h00, 1, 0, 0);
    step(0, 2'd1, 8'h00, 1, 1, 0);
    chk("R4 closing sync done", convDone, 1);
    chk("R5 tick count", {dataHi, dataLo}, 10);
    repeat (4) step(0, 2'd1, 8'h00, 1, 0, 1);
    step(0, 2'd1, 8'h00, 1, 1, 1);
    chk("R4 chained period", {dataHi, dataLo}, 5);

    // R5 external, photodiode-count command 1xx100xx
    step(1, 2'd0, 8'h90, 1, 0, 0);
    step(0, 2'd1, 8'h00, 1, 1, 0);
    for (int j = 1; j <= 20; j++) step(0, 2'd1, 8'h00, 1, j == 20, (j % 2) == 0);
    chk("R5 photo count", {dataHi, dataLo}, 10);

    // R5 bit 7 clear with 101 pattern still gives photo count
    step(1, 2'd0, 8'h14, 1, 0, 0);
    step(0, 2'd1, 8'h00, 1, 1, 0);
    for (int j = 1; j <= 6; j++) step(0, 2'd1, 8'h00, 1, j == 6, 0);
    chk("R5 bit7 clear selects photo", {dataHi, dataLo}, 0);
    chk("R9 range external", rangeCode, 0);

    // R6 external saturation
    step(1, 2'd0, 8'h92, 1, 0, 0);
    step(0, 2'd1, 8'h00, 1, 1, 1);
    for (int j = 1; j <= 70000; j++) step(0, 2'd1, 8'h00, 1, j == 70000, 1);
    chk("R6 external saturation", {dataHi, dataLo}, 65535);
    chk("R9 range 2", rangeCode, 2);

    finishRun();
  end
endmodule